// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic tick source for a processor subsystem. A 24-bit counter is loaded from a software-set reload value and counts down by one on each count event. When it reaches zero it reloads on the next event and keeps running with no software action. When its interrupt enable is set, each pass from one to zero produces an interrupt request.

Count events come from one of two sources, chosen by a control bit. The first is every processor clock cycle. The second is the rising edges of an external reference signal. That signal is never used as a clock: it is synchronised into the processor clock domain, and each detected rising edge is one count event. Both of its phases last longer than one processor clock period.

Software reaches the block through a simple word-wide register port. Writes take effect on the clock edge. Read data is a combinational function of the address. A read-only calibration register returns a tied-off input value, which is the reload count for a 10 ms period.

Top module: `tick_timer`

## Requirements
- R1: After reset, all registers read zero and `irq` is low. While enabled, each count event lowers a non-zero current value by one. With no count event, the current value holds.
- R2: A count event that finds the current value at zero loads the reload value. With a reload value of R, processor-clock counting gives one wrap every R+1 cycles.
- R3: `irq` is a one-cycle pulse. It is high in the cycle after a count event takes the value from 1 to 0, and only when control bit 1 (interrupt enable) is set.
- R4: Control bit 16 (count flag) sets on every pass from 1 to 0, whatever the interrupt enable. A read of the control register returns the flag and then clears it. If the flag sets in the same cycle as the read, the set wins.
- R5: With control bit 2 at 0, a count event occurs on every processor clock. With bit 2 at 1, one count event occurs per rising edge of `ref_in`, after a two-flop synchroniser and an edge detector, and processor clocks alone do not count. If the external option is built out, bit 2 reads 0.
- R6: A write of any value to the current-value register clears the current value and the count flag, and raises no interrupt. The next count event then loads the reload value.
- R7: With a reload value of zero, the counter stays at zero after its next wrap and raises no further interrupts or flags.
- R8: Register map: 0 is control, 1 is reload (24 bits, upper bits read 0), 2 is current value, and 3 is calibration. Calibration reads `cal_in` zero-extended, and writes to it are ignored.
- R9: With control bit 0 (enable) clear, no count events occur and the current value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flag on a control read) |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| ref_in | input | 1 | External timing reference, asynchronous |
| cal_in | input | 24 | Tied-off calibration value |
| irq | output | 1 | Tick interrupt pulse |

## Verification
Some internal faults show at `irq` within one tick period: a wrong decrement, a missed reload or a stale zero detect. In that case the gap between interrupt pulses differs from reload+1 cycles, and the sweep over small reload values measures that gap directly. A flag that fails to set or to clear is visible on the next two control reads. A synchroniser that counts the wrong edges gives a wrong current value a few cycles after a known number of reference edges. If the synchroniser counts on the processor clock instead, the current value keeps moving while the reference is quiet.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CUR    = 2'd2,
    SEL_CAL    = 2'd3
  } reg_sel_e;

  localparam int BIT_EN   = 0;
  localparam int BIT_TINT = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;
endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic rise_o
);
  generate
    if (HAS_EXT) begin : g_sync
      logic s1_q, s2_q, prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          s1_q   <= 1'b0;
          s2_q   <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          s1_q   <= ref_in;
          s2_q   <= s1_q;
          prev_q <= s2_q;
        end
      end
      assign rise_o = s2_q & ~prev_q;

      AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R5
    end else begin : g_none
      logic unused_ref;
      assign unused_ref = ref_in;
      assign rise_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] next_val(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] r);
    return (c == '0) ? r : (c - ONE);
  endfunction

  logic [CNT_W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cur_q <= '0;
    else if (clr_i) cur_q <= '0;
    else if (ev_i)  cur_q <= next_val(cur_q, reload_i);
  end

  assign cur_o  = cur_q;
  assign wrap_o = ev_i && !clr_i && (cur_q == ONE);

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && !clr_i && cur_q != '0) |=> cur_q == $past(cur_q) - ONE); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_i && !clr_i) |=> $stable(cur_q)); // R9
  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && !clr_i && cur_q == '0) |=> cur_q == $past(reload_i)); // R2
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cur_q == '0); // R6
  AST_ZERO_RELOAD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == '0 && reload_i == '0) |=> cur_q == '0); // R7
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int DATA_W  = 32,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cal_i,
  input  logic [CNT_W-1:0]  cur_i,
  input  logic              wrap_i,
  output logic              en_o,
  output logic              src_o,
  output logic              clr_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              irq_o
);
  logic en_q, tint_q, src_q, flag_q, irq_q;
  logic [CNT_W-1:0] reload_q;
  logic wr_ctrl, wr_reload, rd_ctrl;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i;
  assign wr_ctrl   = wr_en_i && (addr_i == SEL_CTRL);
  assign wr_reload = wr_en_i && (addr_i == SEL_RELOAD);
  assign clr_o     = wr_en_i && (addr_i == SEL_CUR);
  assign rd_ctrl   = rd_en_i && (addr_i == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      tint_q <= 1'b0;
      src_q  <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= wdata_i[BIT_EN];
      tint_q <= wdata_i[BIT_TINT];
      src_q  <= HAS_EXT ? wdata_i[BIT_SRC] : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         reload_q <= '0;
    else if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (clr_o)   flag_q <= 1'b0;
    else if (wrap_i)  flag_q <= 1'b1;
    else if (rd_ctrl) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= wrap_i && tint_q;
  end

  always_comb begin
    rdata_o = '0;
    case (reg_sel_e'(addr_i))
      SEL_CTRL: begin
        rdata_o[BIT_EN]   = en_q;
        rdata_o[BIT_TINT] = tint_q;
        rdata_o[BIT_SRC]  = src_q;
        rdata_o[BIT_FLAG] = flag_q;
      end
      SEL_RELOAD: rdata_o[CNT_W-1:0] = reload_q;
      SEL_CUR:    rdata_o[CNT_W-1:0] = cur_i;
      default:    rdata_o[CNT_W-1:0] = cal_i;
    endcase
  end

  assign en_o     = en_q;
  assign src_o    = src_q;
  assign reload_o = reload_q;
  assign irq_o    = irq_q;

  AST_IRQ_NEEDS_TINT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(tint_q)); // R3
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R3
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> flag_q); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !wrap_i) |=> !flag_q); // R4
  AST_CLR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> (!irq_q && !flag_q)); // R6
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W   = 24,
  parameter int DATA_W  = 32,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ref_in,
  input  logic [CNT_W-1:0]  cal_in,
  output logic              irq
);
  logic ref_rise, en, src, clr, wrap, count_ev;
  logic [CNT_W-1:0] reload, cur;

  tick_ref_sync #(.HAS_EXT(HAS_EXT)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rise_o(ref_rise)
  );

  assign count_ev = en && (src ? ref_rise : 1'b1);

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ev_i(count_ev), .clr_i(clr),
    .reload_i(reload), .cur_o(cur), .wrap_o(wrap)
  );

  tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .HAS_EXT(HAS_EXT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cal_i(cal_in),
    .cur_i(cur), .wrap_i(wrap), .en_o(en), .src_o(src), .clr_o(clr),
    .reload_o(reload), .irq_o(irq)
  );

  AST_SRC_GATES_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (src && !ref_rise) |-> !count_ev); // R5
  AST_DISABLED_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !count_ev); // R9
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  localparam logic [23:0] CAL = 24'h1E847F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ref_in = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ref_in(ref_in), .cal_in(CAL), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_irq(output int t);
    int n = 0;
    while (irq !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    t = cyc;
    if (n >= 200) check("R3 irq timeout", 32'd0, 32'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int t1, t2, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq at reset", {31'd0, irq}, 32'd0);
    rd(2'd0, v); check("R1 ctrl reset", v, 32'd0);
    rd(2'd1, v); check("R1 reload reset", v, 32'd0);
    rd(2'd2, v); check("R1 current reset", v, 32'd0);
    // R8 map: reload width, calibration read-only
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R8 reload width", v, 32'h00FF_FFFF);
    rd(2'd3, v); check("R8 calibration", v, {8'd0, CAL});
    wr(2'd3, 32'h0000_1234); rd(2'd3, v); check("R8 cal ignores write", v, {8'd0, CAL});
    // R2 / R3 period sweep
    for (int r = 1; r <= 8; r++) begin
      wr(2'd0, 32'd0); wr(2'd1, r); wr(2'd2, 32'd0); wr(2'd0, 32'd3);
      wait_irq(t1); wait_irq(t2);
      check($sformatf("R2 period reload=%0d", r), t2 - t1, r + 1);
    end
    // R1 decrement, R9 hold when disabled
    wr(2'd0, 32'd0); wr(2'd1, 32'd100); wr(2'd2, 32'd0); wr(2'd0, 32'd1);
    repeat (10) @(negedge clk);
    rd(2'd2, v); repeat (4) @(negedge clk); rd(2'd2, v2);
    check("R1 decrement by five", v - v2, 32'd5);
    wr(2'd0, 32'd0); rd(2'd2, v); repeat (10) @(negedge clk); rd(2'd2, v2);
    check("R9 hold when disabled", v2, v);
    // R6 current write clears value and flag
    wr(2'd0, 32'd1); repeat (3) @(negedge clk);
    wr(2'd2, 32'h00AB_CDEF); rd(2'd2, v); check("R6 current cleared", v, 32'd0);
    rd(2'd2, v); check("R6 loads reload next", v, 32'd100);
    rd(2'd0, v); check("R6 flag clear", v[16], 1'b0);
    // R3 no irq without enable, R4 flag set and read-clear
    wr(2'd0, 32'd0); wr(2'd1, 32'd3); wr(2'd2, 32'd0); wr(2'd0, 32'd1);
    seen = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (irq) seen++; end
    check("R3 no irq when int disabled", seen, 32'd0);
    wr(2'd0, 32'd0);
    rd(2'd0, v); check("R4 flag set", v[16], 1'b1);
    rd(2'd0, v); check("R4 flag cleared by read", v[16], 1'b0);
    // R7 zero reload
    wr(2'd1, 32'd0); wr(2'd2, 32'd0); wr(2'd0, 32'd3);
    seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (irq) seen++; end
    check("R7 no irq at zero reload", seen, 32'd0);
    rd(2'd2, v); check("R7 stays zero", v, 32'd0);
    rd(2'd0, v); check("R7 no flag", v[16], 1'b0);
    // R5 external reference
    wr(2'd0, 32'd0); wr(2'd1, 32'd5); wr(2'd2, 32'd0); wr(2'd0, 32'd5);
    rd(2'd0, v); check("R5 src bit reads back", v[2:0], 3'b101);
    repeat (5) @(negedge clk);
    rd(2'd2, v); check("R5 no count without edges", v, 32'd0);
    for (int e = 0; e < 4; e++) begin
      ref_in = 1'b1; repeat (3) @(negedge clk);
      ref_in = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(2'd2, v); check("R5 four edges counted", v, 32'd2);
    repeat (20) @(negedge clk);
    rd(2'd2, v); check("R5 quiet reference holds", v, 32'd2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule